// File: doc/BRIEF.md
# Byte Output Port with Data-Ready Request

This block sits between a processor data bus and a peripheral. The processor writes one byte by selecting the port and pulsing a write strobe. Selecting takes two inputs of opposite polarity: an active-low select and an active-high select. The captured byte drives the peripheral continuously on `dout`. When a write finishes, the port raises a request line, `srq`, to tell the peripheral that a fresh byte is waiting. An active-low clear input zeros the byte register and withdraws the request, but only while the strobe is low.

The port runs on a fast system clock. The selects, strobe, clear and data are first captured in an input register. Every decision is then made from those captured copies. The write window is the time during which the port is selected and the strobe is high. Inside that window the byte register follows the input byte on every system clock. When the window closes, the register holds the last byte seen.

A three-state sequencer tracks the request:
- **PORT_EMPTY**: no unread byte.
- **PORT_LOAD**: a write window is open.
- **PORT_READY**: a byte has been written and `srq` is high.

The transitions are:
- EMPTY→LOAD, READY→LOAD and LOAD→LOAD ("window open") whenever the sampled window is active.
- LOAD→READY ("window closed") when the window ends without a clear.
- LOAD→EMPTY and READY→EMPTY ("cleared") when the sampled strobe is low and the sampled clear is low.
- Otherwise the state is held ("hold").

Top module: `byte_out_port`

## Requirements
- R1: The port is selected only when `sel_lo_n`=0 and `sel_hi`=1 in the same sample. With any other select combination, a high strobe leaves `dout` unchanged.
- R2: While selected with `stb`=1, `dout` equals the `din` that was applied two system clocks earlier, so it follows every change of `din`.
- R3: During an open write window, `clr_n`=0 has no effect: `dout` still follows `din`.
- R4: When `stb`=0 and `clr_n`=0, `dout` becomes 0x00 two system clocks later.
- R5: When there is no write window and no clear (`stb`=0 with `clr_n`=1, or unselected with `clr_n`=1, or unselected with `stb`=1), `dout` and `srq` keep their values.
- R6: `srq` goes to 1 two system clocks after the write window closes, provided no clear is sampled at that point.
- R7: `srq` is 0 from two system clocks after a write window opens until that window closes, so each written byte gives exactly one request.
- R8: A clear (`stb`=0, `clr_n`=0) drives `srq` to 0 two system clocks later.
- R9: While `rst_n`=0, and right after it, `dout` is 0x00 and `srq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sel_lo_n | input | 1 | Active-low port select |
| sel_hi | input | 1 | Active-high port select |
| stb | input | 1 | Write strobe, active high |
| clr_n | input | 1 | Active-low clear, effective only while `stb` is low |
| din | input | DATA_W (8) | Byte from the processor bus |
| dout | output | DATA_W (8) | Latched byte to the peripheral |
| srq | output | 1 | Data-ready request to the peripheral |

## Verification
Every result is due exactly two system clocks after the stimulus that causes it. The first edge loads the input register. The second edge updates the byte register and the sequencer, and `srq` is decoded from the sequencer state without further delay. The bench therefore changes inputs on a falling edge, lets two rising edges pass, and samples on the next falling edge. It sweeps all sixteen select, strobe and clear combinations from a known loaded state. It then checks the state once more after the controls return to idle, which is the moment a closing window must raise the request.

// File: rtl/port_pkg.sv
`timescale 1ns/1ps
package port_pkg;

    typedef enum logic [1:0] {
        PORT_EMPTY = 2'd0,
        PORT_LOAD  = 2'd1,
        PORT_READY = 2'd2
    } port_state_e;

    typedef struct packed {
        logic sel_lo_n;
        logic sel_hi;
        logic stb;
        logic clr_n;
    } port_ctl_t;

    localparam port_ctl_t CTL_IDLE = '{sel_lo_n: 1'b1, sel_hi: 1'b0, stb: 1'b0, clr_n: 1'b1};

endpackage

// File: rtl/port_sampler.sv
`timescale 1ns/1ps
module port_sampler
    import port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_ctl_t         ctl_in,
    input  logic [DATA_W-1:0] din,
    output port_ctl_t         ctl_q,
    output logic [DATA_W-1:0] din_q
);

    // Single capture stage: all later logic works from these copies only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_IDLE;
            din_q <= '0;
        end else begin
            ctl_q <= ctl_in;
            din_q <= din;
        end
    end

endmodule

// File: rtl/port_decode.sv
`timescale 1ns/1ps
module port_decode
    import port_pkg::*;
(
    input  port_ctl_t ctl_q,
    output logic      selected,
    output logic      win,
    output logic      clr_act
);

    always_comb begin
        selected = !ctl_q.sel_lo_n && ctl_q.sel_hi;
        win      = selected && ctl_q.stb;
        // clear only acts while the strobe is low
        clr_act  = !ctl_q.stb && !ctl_q.clr_n;
    end

endmodule

// File: rtl/port_fsm.sv
`timescale 1ns/1ps
module port_fsm
    import port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win,
    input  logic clr_act,
    output logic srq
);

    port_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_EMPTY: begin
                if (win)          state_d = PORT_LOAD;
            end
            PORT_LOAD: begin
                if (win)          state_d = PORT_LOAD;
                else if (clr_act) state_d = PORT_EMPTY;
                else              state_d = PORT_READY;
            end
            PORT_READY: begin
                if (win)          state_d = PORT_LOAD;
                else if (clr_act) state_d = PORT_EMPTY;
            end
            default:              state_d = PORT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PORT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PORT_READY: srq = 1'b1;
            default:    srq = 1'b0;
        endcase
    end

    assert_req_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PORT_LOAD && !win && !clr_act) |=> srq);

    assert_req_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win |=> !srq);

    assert_req_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> !srq);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PORT_LOAD && !win && !clr_act) |=> $stable(srq));

endmodule

// File: rtl/port_latch.sv
`timescale 1ns/1ps
module port_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win,
    input  logic              clr_act,
    input  logic [DATA_W-1:0] din_q,
    output logic [DATA_W-1:0] dout
);

    // Open window beats clear; clear beats hold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dout <= '0;
        else if (win)     dout <= din_q;
        else if (clr_act) dout <= '0;
    end

    assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win |=> (dout == $past(din_q)));

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (dout == '0));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!win && !clr_act) |=> $stable(dout));

endmodule

// File: rtl/byte_out_port.sv
`timescale 1ns/1ps
module byte_out_port
    import port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              stb,
    input  logic              clr_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              srq
);

    port_ctl_t         ctl_in, ctl_q;
    logic [DATA_W-1:0] din_q;
    logic              selected, win, clr_act;

    always_comb begin
        ctl_in.sel_lo_n = sel_lo_n;
        ctl_in.sel_hi   = sel_hi;
        ctl_in.stb      = stb;
        ctl_in.clr_n    = clr_n;
    end

    port_sampler #(.DATA_W(DATA_W)) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_in (ctl_in),
        .din    (din),
        .ctl_q  (ctl_q),
        .din_q  (din_q)
    );

    port_decode u_decode (
        .ctl_q    (ctl_q),
        .selected (selected),
        .win      (win),
        .clr_act  (clr_act)
    );

    port_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .win     (win),
        .clr_act (clr_act),
        .srq     (srq)
    );

    port_latch #(.DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .win     (win),
        .clr_act (clr_act),
        .din_q   (din_q),
        .dout    (dout)
    );

    // A strobe without both selects must not open a window.
    assert_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.stb && !selected && ctl_q.clr_n) |=> $stable(dout));

endmodule

// File: tb/byte_out_port_test.sv
`timescale 1ns/1ps
module byte_out_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_lo_n = 1'b1, sel_hi = 1'b0, stb = 1'b0, clr_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       srq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    byte_out_port #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
        .stb(stb), .clr_n(clr_n), .din(din), .dout(dout), .srq(srq)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s dout actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s srq actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic drive(input logic lo_n, input logic hi, input logic s,
                         input logic c, input logic [7:0] d);
        sel_lo_n = lo_n; sel_hi = hi; stb = s; clr_n = c; din = d;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(2);
        chk8("R9", dout, 8'h00);
        chk1("R9", srq, 1'b0);
        rst_n = 1'b1;
        step(3);
        chk8("R9", dout, 8'h00);
        chk1("R9", srq, 1'b0);

        // Sweep all select / strobe / clear combinations from a loaded state
        for (int c = 0; c < 16; c++) begin
            logic [7:0] v, w, exp_d;
            logic sel, win, clr, exp_r;
            v = 8'(c * 13 + 7);
            w = ~v;
            drive(1'b0, 1'b1, 1'b1, 1'b1, v);
            step(1);
            drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
            step(2);
            chk8("R2", dout, v);
            chk1("R6", srq, 1'b1);

            drive(c[3], c[2], c[1], c[0], w);
            step(2);
            sel   = !c[3] && c[2];
            win   = sel && c[1];
            clr   = !c[1] && !c[0];
            exp_d = win ? w : (clr ? 8'h00 : v);
            exp_r = (win || clr) ? 1'b0 : 1'b1;
            chk8(win ? (c[0] ? "R2" : "R3") : (clr ? "R4" : (sel ? "R5" : "R1")), dout, exp_d);
            chk1(win ? "R7" : (clr ? "R8" : "R5"), srq, exp_r);

            drive(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF);
            step(2);
            chk8(win ? "R6" : "R5", dout, exp_d);
            chk1(win ? "R6" : "R5", srq, win ? 1'b1 : exp_r);
        end

        // Transparent window: dout tracks every byte, request stays low
        drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
        for (int i = 0; i < 256; i++) begin
            din = 8'(i * 37 + 3);
            step(2);
            chk8("R2", dout, 8'(i * 37 + 3));
            if (i % 32 == 0) chk1("R7", srq, 1'b0);
        end
        drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        step(2);
        chk8("R5", dout, 8'(255 * 37 + 3));
        chk1("R6", srq, 1'b1);
        step(20);
        chk1("R5", srq, 1'b1);

        // Window closing together with a clear: clear wins
        drive(1'b0, 1'b1, 1'b1, 1'b1, 8'hA5);
        step(1);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        step(2);
        chk8("R4", dout, 8'h00);
        chk1("R8", srq, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);

        // Reset in mid-run
        drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h3C);
        step(1);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
        step(2);
        chk1("R6", srq, 1'b1);
        rst_n = 1'b0;
        #1;
        chk8("R9", dout, 8'h00);
        chk1("R9", srq, 1'b0);
        step(1);
        rst_n = 1'b1;
        step(2);
        chk8("R9", dout, 8'h00);
        chk1("R9", srq, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule